// File: doc/BRIEF.md
# Translation Cache with Recency Replacement and Page-Table Walk

This block turns virtual addresses into physical addresses. An address splits into a page number in its upper bits and a byte offset in its low bits. All slots of a small fully associative cache compare the page number at the same moment. A hit returns the cached frame and marks that slot as the most recently used. A miss reads a page table held inside the block. A valid table entry fills a cache slot and completes the translation. An invalid entry reports a page fault. A page number beyond the table reports out of bounds.

Recency is kept as a timestamp per slot. The timestamps are taken from one shared counter, which advances on every hit and every fill. A separate load port writes the page table. While a miss is being served the block raises a busy flag, and a new request is ignored during that time.

Top module: `tlb_walker`

## Requirements
- R1: After reset every cache slot is invalid, the stamp counter is zero, busy_o and resp_valid_o are low, and the first request to any page misses.
- R2: The page number is vaddr[23:12] and the offset is vaddr[11:0]. A successful translation gives resp_paddr_o = {frame[11:0], offset}.
- R3: A request is accepted when req_valid_i is high and busy_o is low. If a valid slot holds its page number, the response comes in the cycle after acceptance with resp_hit_o=1 and the cached frame, and that slot takes the counter's value as its stamp.
- R4: On a miss, busy_o is high in the cycle after acceptance and resp_valid_o is low. The response follows one cycle later. A request presented while busy_o is high is ignored and never produces a response.
- R5: On a miss to a valid table entry, the response has resp_hit_o=0, resp_fault_o=0, resp_oob_o=0 and the translated address. A slot is loaded with the mapping, and later requests to that page hit.
- R6: On a miss to an invalid table entry, the response has resp_fault_o=1 and resp_paddr_o=0. No slot and no stamp changes, so the counter holds.
- R7: A page number at or above PT_DEPTH (1024) gets resp_oob_o=1 and resp_paddr_o=0, and nothing is filled.
- R8: A fill uses the lowest-indexed invalid slot if one exists. Otherwise it uses the valid slot with the smallest stamp, taking the lowest index on a tie. It stamps that slot with the counter, and the counter then advances by one.
- R9: A write on the load port sets the frame and valid bit of table entry pt_idx_i. It leaves cached slots unchanged, so a cached page keeps returning its old frame.
- R10: If a table write hits the entry that a walk reads in the same cycle, the walk uses the value from before the write, and the write takes effect for later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 24 | Virtual address |
| busy_o | output | 1 | Miss in progress; requests ignored |
| resp_valid_o | output | 1 | Response strobe, one cycle |
| resp_hit_o | output | 1 | Response came from the cache |
| resp_fault_o | output | 1 | Table entry invalid |
| resp_oob_o | output | 1 | Page number beyond the table |
| resp_paddr_o | output | 24 | Physical address |
| pt_we_i | input | 1 | Page-table write strobe |
| pt_idx_i | input | 10 | Page-table entry index |
| pt_pfn_i | input | 12 | Frame number to store |
| pt_valid_i | input | 1 | Valid bit to store |

## Verification
Two functions can fall in the same cycle: a table-walk read and a load-port write to the same table entry. The bench provokes this by writing a new frame to the walked page during the busy cycle, in some directed misses and in many random ones. It then expects the pre-write frame in the response and the new frame on the next walk of that page. The busy cycle is also used to present a second request, which must not produce a response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/tlb_page_table.sv
module tlb_page_table #(
  parameter int DEPTH = 1024,
  parameter int PFN_W = 12,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  logic          wr_valid_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [PFN_W-1:0] rd_pfn_o,
  output logic          rd_valid_o
);
  logic [PFN_W-1:0] pfn_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) pfn_mem[wr_idx_i] <= wr_pfn_i;
  end

  // async read: same-cycle write is seen only after the edge
  assign rd_pfn_o   = pfn_mem[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(wr_idx_i)] == $past(wr_valid_i));
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 12,
  parameter int PFN_W   = 12,
  parameter int TS_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] look_vpn_i,
  input  logic             upd_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [TS_W-1:0]    ts_q  [ENTRIES];
  logic [TS_W-1:0]    ctr_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, vict;
  logic [TS_W:0]      best_key;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == look_vpn_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit_o     = |match;
  assign hit_pfn_o = pfn_q[hit_idx];

  // invalid slots rank below any valid slot; strict < keeps lowest index on ties
  always_comb begin
    vict     = '0;
    best_key = {vld_q[0], ts_q[0]};
    for (int i = 1; i < ENTRIES; i++) begin
      if ({vld_q[i], ts_q[i]} < best_key) begin
        best_key = {vld_q[i], ts_q[i]};
        vict     = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ctr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ts_q[i] <= '0;
    end else if (upd_i) begin
      ts_q[hit_idx] <= ctr_q;
      ctr_q         <= ctr_q + 1'b1;
    end else if (fill_i) begin
      vld_q[vict] <= 1'b1;
      ts_q[vict]  <= ctr_q;
      ctr_q       <= ctr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !upd_i) begin
      vpn_q[vict] <= fill_vpn_i;
      pfn_q[vict] <= fill_pfn_i;
    end
  end

  a_r8_one_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r8_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i || fill_i) |=> ctr_q == $past(ctr_q) + 1'b1);
  a_r6_ctr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i || fill_i) |=> $stable(ctr_q) && $stable(vld_q));
  a_r5_fill_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> vld_q[$past(vict)]);
  a_r8_fill_no_evict_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&vld_q)) |=> $countones(vld_q) == $countones($past(vld_q)) + 1);
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 12,
  parameter int OFF_W    = 12,
  parameter int PFN_W    = 12,
  parameter int PT_DEPTH = 1024,
  parameter int TS_W     = 16,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int PT_IW = $clog2(PT_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  output logic            busy_o,
  output logic            resp_valid_o,
  output logic            resp_hit_o,
  output logic            resp_fault_o,
  output logic            resp_oob_o,
  output logic [PA_W-1:0] resp_paddr_o,
  input  logic            pt_we_i,
  input  logic [PT_IW-1:0] pt_idx_i,
  input  logic [PFN_W-1:0] pt_pfn_i,
  input  logic            pt_valid_i
);
  import tlb_pkg::*;

  walk_st_e         state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             accept, hit, fill, oob;
  logic [PFN_W-1:0] hit_pfn, pt_pfn;
  logic             pt_vld;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign busy_o = (state_q == ST_WALK);
  assign oob    = {1'b0, vpn_q} >= (VPN_W+1)'(PT_DEPTH);
  assign fill   = busy_o && !oob && pt_vld;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .TS_W(TS_W)) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_vpn_i (req_vaddr_i[VA_W-1:OFF_W]),
    .upd_i      (accept && hit),
    .fill_i     (fill),
    .fill_vpn_i (vpn_q),
    .fill_pfn_i (pt_pfn),
    .hit_o      (hit),
    .hit_pfn_o  (hit_pfn)
  );

  tlb_page_table #(.DEPTH(PT_DEPTH), .PFN_W(PFN_W)) u_pt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (pt_we_i),
    .wr_idx_i   (pt_idx_i),
    .wr_pfn_i   (pt_pfn_i),
    .wr_valid_i (pt_valid_i),
    .rd_idx_i   (vpn_q[PT_IW-1:0]),
    .rd_pfn_o   (pt_pfn),
    .rd_valid_o (pt_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      vpn_q        <= '0;
      off_q        <= '0;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_fault_o <= 1'b0;
      resp_oob_o   <= 1'b0;
      resp_paddr_o <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept && hit) begin
          resp_valid_o <= 1'b1;
          resp_hit_o   <= 1'b1;
          resp_fault_o <= 1'b0;
          resp_oob_o   <= 1'b0;
          resp_paddr_o <= {hit_pfn, req_vaddr_i[OFF_W-1:0]};
        end else if (accept) begin
          state_q <= ST_WALK;
          vpn_q   <= req_vaddr_i[VA_W-1:OFF_W];
          off_q   <= req_vaddr_i[OFF_W-1:0];
        end
      end else begin
        state_q      <= ST_IDLE;
        resp_valid_o <= 1'b1;
        resp_hit_o   <= 1'b0;
        resp_oob_o   <= oob;
        resp_fault_o <= !oob && !pt_vld;
        resp_paddr_o <= fill ? {pt_pfn, off_q} : '0;
      end
    end
  end

  a_r3_hit_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> resp_valid_o && resp_hit_o);
  a_r4_miss_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit) |=> busy_o && !resp_valid_o);
  a_r4_walk_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o && resp_valid_o && !resp_hit_o);
  a_r6_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot0({resp_hit_o, resp_fault_o, resp_oob_o}));
  a_r7_oob_no_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (resp_oob_o || resp_fault_o) |-> resp_paddr_o == '0);
endmodule

// File: tb/tlb_walker_test.sv
module tlb_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_vaddr = '0;
  logic busy, resp_valid, resp_hit, resp_fault, resp_oob;
  logic [23:0] resp_paddr;
  logic pt_we = 1'b0;
  logic [9:0] pt_idx = '0;
  logic [11:0] pt_pfn = '0;
  logic pt_valid = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlb_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .busy_o(busy), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_fault_o(resp_fault), .resp_oob_o(resp_oob), .resp_paddr_o(resp_paddr),
    .pt_we_i(pt_we), .pt_idx_i(pt_idx), .pt_pfn_i(pt_pfn), .pt_valid_i(pt_valid)
  );

  // reference model
  bit        m_vld [16];
  int        m_vpn [16];
  int        m_pfn [16];
  int        m_ts  [16];
  int        m_ctr;
  int        t_pfn [1024];
  bit        t_vld [1024];

  function automatic int m_find(int vpn);
    for (int i = 0; i < 16; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < 16; i++) if (!m_vld[i]) return i;
    begin
      int b = 0;
      for (int i = 1; i < 16; i++) if (m_ts[i] < m_ts[b]) b = i;
      return b;
    end
  endfunction

  task automatic chk(bit ok, string req, longint got, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic pt_write(int idx, int pfn, bit v);
    @(negedge clk);
    pt_we = 1'b1; pt_idx = 10'(idx); pt_pfn = 12'(pfn); pt_valid = v;
    @(negedge clk);
    pt_we = 1'b0;
    t_pfn[idx] = pfn; t_vld[idx] = v;
  endtask

  // sneak: extra request during busy; clash: table write to walked entry during busy
  task automatic translate(int vpn, int off, bit sneak, bit clash, output bit got_hit);
    int idx = m_find(vpn);
    int exp_pa;
    int clash_pfn = int'($urandom_range(0, 4095));
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {12'(vpn), 12'(off)};
    @(negedge clk);
    req_valid = 1'b0;
    got_hit = resp_hit && resp_valid;
    if (idx >= 0) begin
      exp_pa = (m_pfn[idx] << 12) | off;
      chk(resp_valid && resp_hit, "R3 hit flag", {resp_valid, resp_hit}, 2'b11);
      chk(resp_paddr == 24'(exp_pa), "R2 hit paddr", resp_paddr, exp_pa);
      m_ts[idx] = m_ctr; m_ctr++;
      return;
    end
    chk(busy && !resp_valid, "R4 busy after miss", {busy, resp_valid}, 2'b10);
    if (sneak) begin req_valid = 1'b1; req_vaddr = 24'($urandom); end
    if (clash && vpn < 1024) begin
      pt_we = 1'b1; pt_idx = 10'(vpn); pt_pfn = 12'(clash_pfn); pt_valid = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0; pt_we = 1'b0;
    chk(resp_valid && !busy && !resp_hit, "R4 miss response", {resp_valid, busy, resp_hit}, 3'b100);
    if (vpn >= 1024) begin
      chk(resp_oob && !resp_fault && resp_paddr == 0, "R7 out of bounds",
          {resp_oob, resp_fault, resp_paddr}, {2'b10, 24'h0});
    end else if (!t_vld[vpn]) begin
      chk(resp_fault && !resp_oob && resp_paddr == 0, "R6 fault",
          {resp_fault, resp_oob, resp_paddr}, {2'b10, 24'h0});
    end else begin
      int v = m_victim();
      exp_pa = (t_pfn[vpn] << 12) | off;
      chk(!resp_fault && !resp_oob && resp_paddr == 24'(exp_pa), "R5 fill paddr (R10 old value)",
          {resp_fault, resp_oob, resp_paddr}, {2'b00, 24'(exp_pa)});
      m_vld[v] = 1'b1; m_vpn[v] = vpn; m_pfn[v] = t_pfn[vpn]; m_ts[v] = m_ctr; m_ctr++;
    end
    if (clash && vpn < 1024) begin t_pfn[vpn] = clash_pfn; t_vld[vpn] = 1'b1; end
    if (sneak) begin
      @(negedge clk);
      chk(!resp_valid && !busy, "R4 busy request ignored", {resp_valid, busy}, 2'b00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit h;
    void'($urandom(32'd1234));
    m_ctr = 0;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_ts[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; end
    for (int i = 0; i < 1024; i++) begin t_vld[i] = 0; t_pfn[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !resp_valid, "R1 reset outputs", {busy, resp_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !resp_valid, "R1 idle after reset", {busy, resp_valid}, 2'b00);

    // R1/R6: empty table faults
    translate(5, 12'h123, 0, 0, h);
    chk(!h, "R1 first request misses", h, 0);
    // R2/R5/R3
    pt_write(5, 12'hABC, 1);
    translate(5, 12'h123, 0, 0, h);
    chk(resp_paddr == 24'hABC123, "R2 concatenation", resp_paddr, 24'hABC123);
    translate(5, 12'hFFF, 0, 0, h);
    chk(h, "R5 later request hits", h, 1);
    // R6: fault leaves cache unchanged
    translate(7, 0, 0, 0, h);
    pt_write(7, 12'h077, 1);
    translate(7, 12'h010, 0, 0, h);
    chk(!h, "R6 fault did not fill", h, 0);
    // R7
    translate(12'h800, 12'h055, 0, 0, h);
    translate(1024, 0, 0, 0, h);
    translate(1024, 0, 0, 0, h);
    chk(!h, "R7 out-of-bounds not cached", h, 0);
    // R8: fill the remaining slots, refresh some, then evict
    for (int v = 100; v < 114; v++) begin pt_write(v, v + 1, 1); translate(v, 0, 0, 0, h); end
    translate(5, 1, 0, 0, h);
    translate(7, 1, 0, 0, h);
    translate(100, 1, 0, 0, h);
    pt_write(200, 12'h222, 1);
    translate(200, 0, 0, 0, h);      // evicts 101, oldest untouched
    translate(101, 0, 0, 0, h);      // table entry valid, so refill
    chk(!h, "R8 least recent slot evicted", h, 0);
    translate(100, 2, 0, 0, h);
    chk(h, "R8 refreshed slot kept", h, 1);
    // R9: table write does not touch the cache
    pt_write(5, 12'h555, 1);
    translate(5, 12'h004, 0, 0, h);
    chk(h && resp_paddr == 24'hABC004, "R9 cached frame kept", resp_paddr, 24'hABC004);
    // R10: clash of walk read and table write
    pt_write(300, 12'h300, 1);
    translate(300, 12'h0AA, 0, 1, h);
    chk(resp_paddr == 24'h3000AA, "R10 walk used old entry", resp_paddr, 24'h3000AA);
    // R4: request during busy is dropped
    pt_write(301, 12'h301, 1);
    translate(301, 0, 1, 0, h);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom_range(0, 99));
      int vpn = int'($urandom_range(0, 39)) + 400;
      if (r < 20) pt_write(vpn, int'($urandom_range(0, 4095)), $urandom_range(0, 9) < 8);
      else begin
        if (r >= 95) vpn = int'($urandom_range(1024, 4095));
        translate(vpn, int'($urandom_range(0, 4095)), $urandom_range(0, 9) == 0,
                  $urandom_range(0, 4) == 0, h);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule